// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a bank of up to eight SDRAM rows from power-up to normal operation with no software stepping. After a start pulse it waits for power to settle. It then issues a no-operation command, a precharge-all, eight auto-refresh (CBR) rounds and a mode-register write. Between these steps it holds the required waits with a down-counter. It then enters normal mode, turns on refresh and raises a done flag.

Each command other than normal is walked across the rows in ascending order, one row per clock. The sequencer finds empty rows from the cumulative row-boundary values supplied at its input, and it drives no command to them. The mode-register address is built from the selected CAS latency. Rows in the upper half of the bank receive this address with selected bits inverted, to match the way those rows are wired.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and after reset is released, cmd_valid_o, busy_o, done_o and refresh_en_o are 0 and cmd_o is 000.
- R2: Command codes on cmd_o are normal=000, no-op=001, precharge-all=010, mode-register-write=011 and auto-refresh=100.
- R3: After start_i is sampled, the phases follow in a fixed order, each taking this many clocks: power wait (PWR_WAIT), no-op issue (8), wait (NOP_WAIT, 200 by default), precharge issue (8), tRP wait, then eight rounds of refresh issue (8) plus tRC wait, then mode issue (8), wait (MRS_WAIT, 2 by default), one normal clock, and done.
- R4: Within an issue phase, row_o steps through rows 0 to 7, one per clock. cmd_valid_o is 1 only for present rows. Row r is present when its 8-bit boundary value (bound_i[8r+7:8r]) differs from that of row r-1. For row 0 the comparison is against 0.
- R5: The normal-mode clock shows cmd_o=000 with cmd_valid_o low, so no row receives it.
- R6: The mode-register address is 13'h032 for CAS latency 3 (cas_lat3_i=1) and 13'h022 for CAS latency 2. For rows 4 to 7, bits [12:11] and [9:0] of this address are inverted, which gives 13'h1BCD and 13'h1BDD. addr_o is 0 outside the mode phase.
- R7: The tRP and tRC wait lengths are taken from trp_cyc_i and trc_cyc_i when their wait is entered. A value of 0 is treated as 1.
- R8: A start_i pulse while busy_o is high has no effect on the command stream or its timing.
- R9: With every row empty, all phases still run for their full length, no command is valid, and done arrives at the same clock as for a populated bank.
- R10: From the clock after the normal-mode clock, done_o and refresh_en_o are 1 and busy_o is 0 until the next start_i, which restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the sequence (taken when not busy) |
| cas_lat3_i | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| bound_i | input | 64 | Eight cumulative row boundaries, row r in bits [8r+7:8r] |
| trp_cyc_i | input | 16 | Precharge wait length in clocks |
| trc_cyc_i | input | 16 | Wait length after each refresh round in clocks |
| cmd_o | output | 3 | Command code of the current phase |
| cmd_valid_o | output | 1 | Command is driven to row_o this clock |
| row_o | output | 3 | Target row index |
| addr_o | output | 13 | Address bus (mode-register value during the mode phase) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |
| refresh_en_o | output | 1 | Periodic refresh may run |

## Verification
The assertions assume that bound_i, cas_lat3_i and the two wait-length inputs are held steady while busy_o is high, and that the boundary values never decrease from row to row. The bench changes these inputs only between runs, at a falling edge while the block is idle or done. Within each run it uses one of three boundary patterns: all rows present, a sparse pattern with upper-half rows present, and all rows empty. It also sends one extra start pulse in the middle of a run. The expected stream of row commands is derived from the phase lengths and compared by clock index, so any shift in a wait or any skipped-row error is caught.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    CMD_NORMAL = 3'b000,
    CMD_NOP    = 3'b001,
    CMD_PALL   = 3'b010,
    CMD_MRS    = 3'b011,
    CMD_CBR    = 3'b100
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR, S_NOP, S_NOP_W, S_PRE, S_PRE_W,
    S_CBR, S_CBR_W, S_MRS, S_MRS_W, S_NORM, S_DONE
  } state_e;

  localparam int unsigned MODE_W = 13;
  // bits [12:11] and [9:0] flip for upper-half rows
  localparam logic [MODE_W-1:0] MODE_INV_MASK = 13'h1BFF;
endpackage

// File: rtl/sdram_row_scan.sv
module sdram_row_scan #(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned BND_W    = 8,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic [NUM_ROWS*BND_W-1:0] bound_i,
  input  logic [ROW_W-1:0]          row_i,
  output logic                      present_o
);
  logic [NUM_ROWS-1:0] present;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    if (g == 0) begin : g_first
      assign present[g] = bound_i[BND_W-1:0] != '0;
    end else begin : g_next
      assign present[g] = bound_i[g*BND_W +: BND_W] != bound_i[(g-1)*BND_W +: BND_W];
    end
  end

  assign present_o = present[row_i];
endmodule

// File: rtl/sdram_wait_cnt.sv
module sdram_wait_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (len_i == '0) ? CNT_W'(1) : len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = cnt_q == CNT_W'(1);
endmodule

// File: rtl/sdram_mrs_addr.sv
module sdram_mrs_addr
  import sdram_init_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic              cas3_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [MODE_W-1:0] addr_o
);
  logic [MODE_W-1:0] base;

  // burst 4, sequential, latency in [6:4]
  assign base   = {6'b0, (cas3_i ? 3'd3 : 3'd2), 1'b0, 3'b010};
  assign addr_o = (row_i >= ROW_W'(NUM_ROWS/2)) ? (base ^ MODE_INV_MASK) : base;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned NUM_ROWS  = 8,
  parameter int unsigned BND_W     = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned PWR_WAIT  = 16,
  parameter int unsigned NOP_WAIT  = 200,
  parameter int unsigned MRS_WAIT  = 2,
  parameter int unsigned CBR_COUNT = 8,
  localparam int unsigned ROW_W    = $clog2(NUM_ROWS),
  localparam int unsigned CBR_W    = $clog2(CBR_COUNT + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      cas_lat3_i,
  input  logic [NUM_ROWS*BND_W-1:0] bound_i,
  input  logic [CNT_W-1:0]          trp_cyc_i,
  input  logic [CNT_W-1:0]          trc_cyc_i,
  output logic [2:0]                cmd_o,
  output logic                      cmd_valid_o,
  output logic [ROW_W-1:0]          row_o,
  output logic [MODE_W-1:0]         addr_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      refresh_en_o
);
  state_e            state_q, state_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [CBR_W-1:0]  cbr_q, cbr_d;
  logic              wt_load, wt_expire, row_present, issue, last_row;
  logic [CNT_W-1:0]  wt_len;
  logic [MODE_W-1:0] mrs_addr;
  cmd_e              phase_cmd;

  sdram_row_scan #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_scan (
    .bound_i(bound_i), .row_i(row_q), .present_o(row_present));

  sdram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wt_load), .len_i(wt_len),
    .expire_o(wt_expire));

  sdram_mrs_addr #(.NUM_ROWS(NUM_ROWS)) u_mrs (
    .cas3_i(cas_lat3_i), .row_i(row_q), .addr_o(mrs_addr));

  assign issue    = state_q inside {S_NOP, S_PRE, S_CBR, S_MRS};
  assign last_row = row_q == ROW_W'(NUM_ROWS - 1);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    cbr_d   = cbr_q;
    wt_load = 1'b0;
    wt_len  = '0;
    if (issue) row_d = last_row ? '0 : row_q + 1'b1;
    unique case (state_q)
      S_IDLE, S_DONE: if (start_i) begin
        state_d = S_PWR; wt_load = 1'b1; wt_len = CNT_W'(PWR_WAIT);
      end
      S_PWR:   if (wt_expire) state_d = S_NOP;
      S_NOP:   if (last_row) begin
        state_d = S_NOP_W; wt_load = 1'b1; wt_len = CNT_W'(NOP_WAIT);
      end
      S_NOP_W: if (wt_expire) state_d = S_PRE;
      S_PRE:   if (last_row) begin
        state_d = S_PRE_W; wt_load = 1'b1; wt_len = trp_cyc_i;
      end
      S_PRE_W: if (wt_expire) begin state_d = S_CBR; cbr_d = '0; end
      S_CBR:   if (last_row) begin
        state_d = S_CBR_W; wt_load = 1'b1; wt_len = trc_cyc_i;
      end
      S_CBR_W: if (wt_expire) begin
        if (cbr_q == CBR_W'(CBR_COUNT - 1)) state_d = S_MRS;
        else begin state_d = S_CBR; cbr_d = cbr_q + 1'b1; end
      end
      S_MRS:   if (last_row) begin
        state_d = S_MRS_W; wt_load = 1'b1; wt_len = CNT_W'(MRS_WAIT);
      end
      S_MRS_W: if (wt_expire) state_d = S_NORM;
      S_NORM:  state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      row_q   <= '0;
      cbr_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      cbr_q   <= cbr_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_NOP:   phase_cmd = CMD_NOP;
      S_PRE:   phase_cmd = CMD_PALL;
      S_CBR:   phase_cmd = CMD_CBR;
      S_MRS:   phase_cmd = CMD_MRS;
      default: phase_cmd = CMD_NORMAL;
    endcase
  end

  assign cmd_o        = phase_cmd;
  assign cmd_valid_o  = issue && row_present;
  assign row_o        = row_q;
  assign addr_o       = (state_q == S_MRS) ? mrs_addr : '0;
  assign busy_o       = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o       = state_q == S_DONE;
  assign refresh_en_o = state_q == S_DONE;

  assert_valid_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);
  assert_normal_not_sent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_o != CMD_NORMAL);
  assert_row_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && $past(cmd_valid_o) && cmd_o == $past(cmd_o)) |-> row_o > $past(row_o));
  assert_mrs_low_rows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_MRS && row_o < ROW_W'(NUM_ROWS/2))
      |-> (addr_o[12:7] == '0 && addr_o[3:0] == 4'b0010));
  assert_mrs_high_rows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_MRS && row_o >= ROW_W'(NUM_ROWS/2))
      |-> (addr_o[12:11] == 2'b11 && addr_o[10] == 1'b0));
  assert_done_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (refresh_en_o && !busy_o));
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  assert_done_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
  import sdram_init_pkg::*;
  localparam int NR = 8, BW = 8, CW = 16, PWR = 16, NOPW = 200, MRSW = 2, NCBR = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cas3 = 1'b0;
  logic [NR*BW-1:0] bnd = '0;
  logic [CW-1:0] trp = '0, trc = '0;
  logic [2:0] cmd, row;
  logic valid, busy, done, refr;
  logic [12:0] addr;

  sdram_init_seq #(.PWR_WAIT(PWR), .NOP_WAIT(NOPW), .MRS_WAIT(MRSW), .CBR_COUNT(NCBR)) u_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cas_lat3_i(cas3), .bound_i(bnd),
    .trp_cyc_i(trp), .trc_cyc_i(trc), .cmd_o(cmd), .cmd_valid_o(valid), .row_o(row),
    .addr_o(addr), .busy_o(busy), .done_o(done), .refresh_en_o(refr));

  always #4 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [2:0]  row;
    logic [12:0] addr;
    logic [31:0] at;
  } item_t;
  item_t exp_q[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_addr(logic c3, int r);
    logic [12:0] b = c3 ? 13'h032 : 13'h022;
    return (r >= NR/2) ? (b ^ 13'h1BFF) : b;
  endfunction

  function automatic bit row_full(logic [NR*BW-1:0] b, int r);
    logic [BW-1:0] prev = (r == 0) ? '0 : b[(r-1)*BW +: BW];
    return b[r*BW +: BW] != prev;
  endfunction

  task automatic push_phase(logic [2:0] c, int unsigned at, logic [NR*BW-1:0] b, logic c3);
    for (int r = 0; r < NR; r++) begin
      if (row_full(b, r)) begin
        item_t it;
        it.cmd  = c;
        it.row  = 3'(r);
        it.addr = (c == 3'b011) ? exp_addr(c3, r) : 13'h0;
        it.at   = at + r;
        exp_q.push_back(it);
      end
    end
  endtask

  // monitor: pop and compare every driven row command
  always @(negedge clk) begin : mon
    item_t e;
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected row command", {cmd, row}, 0);
      end else begin
        e = exp_q.pop_front();
        check(cmd == e.cmd, "R2", "command code", cmd, e.cmd);
        check(row == e.row, "R4", "row index", row, e.row);
        check(addr == e.addr, "R6", "mode address", addr, e.addr);
        check(cyc == e.at, "R3", "issue clock", cyc, e.at);
      end
    end
  end

  task automatic run_seq(logic [NR*BW-1:0] b, logic c3, int tp, int tc, bit poke, bit empty_run);
    int unsigned s, b0, c0, m, tpx, tcx;
    @(negedge clk);
    bnd = b; cas3 = c3; trp = CW'(tp); trc = CW'(tc);
    @(negedge clk);
    s   = cyc + 1;
    tpx = (tp == 0) ? 1 : tp;   // R7: zero length acts as one
    tcx = (tc == 0) ? 1 : tc;
    push_phase(3'b001, s + PWR, b, c3);
    b0 = s + PWR + 8 + NOPW;
    push_phase(3'b010, b0, b, c3);
    c0 = b0 + 8 + tpx;
    for (int k = 0; k < NCBR; k++) push_phase(3'b100, c0 + k*(8 + tcx), b, c3);
    m = c0 + NCBR*(8 + tcx);
    push_phase(3'b011, m, b, c3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R10", "busy after start", {busy, done}, 2'b10);
    if (poke) begin
      while (cyc < s + 60) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < m + 10) @(negedge clk);
    check(done == 1'b0 && busy == 1'b1, "R5", "normal clock busy", {done, busy}, 2'b01);
    check(cmd == 3'b000 && !valid, "R5", "normal not sent", {cmd, valid}, 0);
    @(negedge clk);
    if (poke) check(done == 1'b1, "R8", "done timing with extra start", done, 1);
    if (empty_run) check(done == 1'b1, "R9", "done timing with empty bank", done, 1);
    check(done == 1'b1, "R10", "done flag", done, 1);
    check(refr == 1'b1, "R10", "refresh enable", refr, 1);
    check(busy == 1'b0, "R10", "busy cleared", busy, 0);
    check(exp_q.size() == 0, empty_run ? "R9" : "R4", "commands missing", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && refr == 1'b1, "R10", "done held", {done, refr}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!valid && !busy && !done && !refr && cmd == 3'b000, "R1", "state in reset",
          {valid, busy, done, refr, cmd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid && !busy && !done && !refr && cmd == 3'b000, "R1", "state after reset",
          {valid, busy, done, refr, cmd}, 0);
    // R3 R6: every row present, latency 3
    run_seq(64'h0807060504030201, 1'b1, 3, 4, 1'b0, 1'b0);
    // R4 R7 R8: sparse rows, latency 2, zero waits, extra start mid-run
    run_seq(64'h0905050202020000, 1'b0, 0, 0, 1'b1, 1'b0);
    // R9: empty bank
    run_seq(64'h0, 1'b1, 5, 2, 1'b0, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule